// File: doc/BRIEF.md
# Triggered Multi-Channel Trend Capture

This block records several 32-bit data channels into an on-chip circular sample store so that the history around an event can be examined later. Each channel chooses between two candidate sources, a real-format word and an integer-format word, through its own select bit. One sample of every channel is written on each cycle that the sample strobe is high while capture is running. A single external trigger pulse divides the record into a pre-trigger part, kept circularly, and a fixed-length post-trigger part.

Capture is armed only by a rising edge of the enable-collect control bit. It ends when the post-trigger part has been stored or when enable-collect is dropped early. Two status flags report Triggered and Complete. Once Complete is set, the trend outputs replay the frozen store at a read pointer. The pointer either follows a host-written value or free-runs through the store at a programmable rate. Until Complete is set, the outputs are held at zero.

The sequencing is a four-state machine. IDLE is the state after reset. ARMED collects pre-trigger samples. POST collects post-trigger samples. DONE holds the captured record. Its transitions are:
- arm: rising edge of enable-collect, from any state, goes to ARMED.
- trigger: a trigger pulse in ARMED with enable high goes to POST.
- fill: the last post-trigger strobe in POST goes to DONE.
- abort: enable-collect low in ARMED or POST goes to DONE.

The store depth must be a power of two.

Top module: `trend_capture`

## Requirements
- R1: A rising edge of control bit 0 (enable-collect) starts a new capture. The write position restarts, and both status bit 1 (Triggered) and status bit 2 (Complete) read 0 on the next cycle. Keeping bit 0 high does not start a new capture.
- R2: Control bits 1 to NCH choose the source of channels 0 to NCH-1. A bit value of 1 selects the real-format input and 0 selects the integer-format input. Channel i occupies bits [32*i+31:32*i] of every channel bus. One sample of all channels is stored per strobe cycle while collecting.
- R3: A trigger pulse while collecting before any trigger sets status bit 1 on the next cycle. The bit stays set until the next rising edge of enable-collect.
- R4: Complete sets on the cycle after the DEPTH-PRE-th strobe that follows the trigger cycle. A strobe in the same cycle as the trigger counts as pre-trigger.
- R5: Dropping enable-collect while collecting stops sampling and sets Complete on the next cycle. If this happens before a trigger, Triggered stays 0.
- R6: Once Complete is set, further strobes, triggers and the fall of enable-collect leave the stored record unchanged.
- R7: While Complete is 0, every trend output bit is 0.
- R8: With Complete set, read pointer k shows the k-th oldest of the last DEPTH samples written. Pointer 0 is the oldest.
- R9: With control bit 15 (auto-output) at 0, the read pointer takes the host pointer value one cycle after that value is applied.
- R10: With control bit 15 at 1, the read pointer advances by one every rate_div+1 cycles and wraps from DEPTH-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_word | input | 16 | Control: bit 0 enable-collect, bits 1..NCH source selects, bit 15 auto-output |
| trig_in | input | 1 | Trigger pulse |
| smp_stb | input | 1 | Sample strobe, one cycle per sample |
| src_real | input | NCH*DW | Real-format channel sources |
| src_int | input | NCH*DW | Integer-format channel sources |
| rate_div | input | RATE_W | Auto-replay divider: cycles between steps minus one |
| host_ptr | input | log2(DEPTH) | Host-written read pointer |
| status_word | output | 16 | Status: bit 1 Triggered, bit 2 Complete, other bits 0 |
| replay_ptr | output | log2(DEPTH) | Current read pointer |
| trend_out | output | NCH*DW | Replayed channel samples, zero until Complete |

## Verification
The bench drives every input on a falling edge and reads the outputs one falling edge later. This timing suits the block: arming, trigger detection, the final strobe, an abort and a new host pointer each show up at the ports exactly one rising edge after the stimulus. Trend data is a combinational read at the registered pointer, so it is due in the same cycle as the pointer. Auto replay is checked cycle by cycle against the count of rising edges since auto mode was entered, and wrap-around is checked with a divider of zero. The expected record is a bench-side model of the store, filled with the samples the bench itself drove.

// File: rtl/trend_pkg.sv
package trend_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_POST  = 2'd2,
        ST_DONE  = 2'd3
    } trend_state_t;

    localparam int CTL_ENABLE = 0;
    localparam int CTL_SEL_LO = 1;
    localparam int CTL_AUTO   = 15;
    localparam int STS_TRIG   = 1;
    localparam int STS_DONE   = 2;

endpackage

// File: rtl/trend_ctrl_fsm.sv
module trend_ctrl_fsm
    import trend_pkg::*;
#(
    parameter int POST_LEN = 48
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         trig,
    input  logic         stb,
    output logic         wr_en,
    output logic         wr_clr,
    output logic         triggered,
    output logic         complete,
    output trend_state_t state
);
    localparam int CW = $clog2(POST_LEN + 1);

    trend_state_t  nxt;
    logic          en_q;
    logic          en_rise;
    logic          last_post;
    logic [CW-1:0] post_cnt;

    assign en_rise   = en & ~en_q;
    assign last_post = (post_cnt == CW'(POST_LEN - 1));

    // next-state
    always_comb begin
        nxt = state;
        if (en_rise) begin
            nxt = ST_ARMED;
        end else begin
            unique case (state)
                ST_IDLE:  nxt = ST_IDLE;
                ST_ARMED: begin
                    if (!en)       nxt = ST_DONE;
                    else if (trig) nxt = ST_POST;
                end
                ST_POST: begin
                    if (!en)                   nxt = ST_DONE;
                    else if (stb && last_post) nxt = ST_DONE;
                end
                ST_DONE:  nxt = ST_DONE;
            endcase
        end
    end

    // state register and sticky flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            en_q      <= 1'b0;
            post_cnt  <= '0;
            triggered <= 1'b0;
            complete  <= 1'b0;
        end else begin
            en_q  <= en;
            state <= nxt;
            if (en_rise) begin
                triggered <= 1'b0;
                complete  <= 1'b0;
                post_cnt  <= '0;
            end else begin
                if (state == ST_ARMED && en && trig)
                    triggered <= 1'b1;
                if (state != ST_DONE && nxt == ST_DONE)
                    complete <= 1'b1;
                if (state == ST_POST && en && stb)
                    post_cnt <= post_cnt + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        wr_clr = en_rise;
        wr_en  = 1'b0;
        unique case (state)
            ST_ARMED, ST_POST: wr_en = stb & en & ~en_rise;
            ST_IDLE, ST_DONE:  wr_en = 1'b0;
        endcase
    end

endmodule

// File: rtl/trend_buffer.sv
module trend_buffer #(
    parameter int NCH   = 4,
    parameter int DW    = 32,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int BW   = NCH * DW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic           wr_clr,
    input  logic [NCH-1:0] sel_real,
    input  logic [BW-1:0]  src_real,
    input  logic [BW-1:0]  src_int,
    input  logic [AW-1:0]  rd_ptr,
    input  logic           show,
    output logic [BW-1:0]  rd_data
);
    logic [BW-1:0] mem [DEPTH];
    logic [BW-1:0] smp;
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_addr;

    for (genvar i = 0; i < NCH; i++) begin : g_sel
        assign smp[i*DW +: DW] = sel_real[i] ? src_real[i*DW +: DW]
                                             : src_int[i*DW +: DW];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      wr_ptr <= '0;
        else if (wr_clr) wr_ptr <= '0;
        else if (wr_en)  wr_ptr <= wr_ptr + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr] <= smp;
    end

    // oldest sample sits at the next write slot
    assign rd_addr = wr_ptr + rd_ptr;
    assign rd_data = show ? mem[rd_addr] : '0;

endmodule

// File: rtl/trend_replay.sv
module trend_replay #(
    parameter int AW     = 6,
    parameter int RATE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              auto_en,
    input  logic [RATE_W-1:0] rate,
    input  logic [AW-1:0]     host_ptr,
    output logic [AW-1:0]     ptr
);
    logic [RATE_W-1:0] div_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr     <= '0;
            div_cnt <= '0;
        end else if (auto_en) begin
            if (div_cnt >= rate) begin
                div_cnt <= '0;
                ptr     <= ptr + 1'b1;
            end else begin
                div_cnt <= div_cnt + 1'b1;
            end
        end else begin
            ptr     <= host_ptr;
            div_cnt <= '0;
        end
    end

endmodule

// File: rtl/trend_capture.sv
module trend_capture
    import trend_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int DW     = 32,
    parameter int DEPTH  = 64,
    parameter int PRE    = 16,
    parameter int RATE_W = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int BW    = NCH * DW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       ctrl_word,
    input  logic              trig_in,
    input  logic              smp_stb,
    input  logic [BW-1:0]     src_real,
    input  logic [BW-1:0]     src_int,
    input  logic [RATE_W-1:0] rate_div,
    input  logic [AW-1:0]     host_ptr,
    output logic [15:0]       status_word,
    output logic [AW-1:0]     replay_ptr,
    output logic [BW-1:0]     trend_out
);
    localparam int POST_LEN = DEPTH - PRE;

    trend_state_t fsm_state;
    logic         wr_en;
    logic         wr_clr;
    logic         triggered;
    logic         complete;
    logic         unused_ctl;
    trend_state_t unused_state;

    assign unused_ctl   = ^ctrl_word[CTL_AUTO-1:CTL_SEL_LO+NCH];
    assign unused_state = fsm_state;

    trend_ctrl_fsm #(.POST_LEN(POST_LEN)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (ctrl_word[CTL_ENABLE]),
        .trig      (trig_in),
        .stb       (smp_stb),
        .wr_en     (wr_en),
        .wr_clr    (wr_clr),
        .triggered (triggered),
        .complete  (complete),
        .state     (fsm_state)
    );

    trend_buffer #(.NCH(NCH), .DW(DW), .DEPTH(DEPTH)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_clr   (wr_clr),
        .sel_real (ctrl_word[CTL_SEL_LO +: NCH]),
        .src_real (src_real),
        .src_int  (src_int),
        .rd_ptr   (replay_ptr),
        .show     (complete),
        .rd_data  (trend_out)
    );

    trend_replay #(.AW(AW), .RATE_W(RATE_W)) u_rep (
        .clk      (clk),
        .rst_n    (rst_n),
        .auto_en  (ctrl_word[CTL_AUTO]),
        .rate     (rate_div),
        .host_ptr (host_ptr),
        .ptr      (replay_ptr)
    );

    always_comb begin
        status_word           = '0;
        status_word[STS_TRIG] = triggered;
        status_word[STS_DONE] = complete;
    end

endmodule

// File: rtl/trend_capture_chk.sv
module trend_capture_chk #(
    parameter int NCH = 4,
    parameter int DW  = 32,
    parameter int AW  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic [15:0]       ctrl_word,
    input logic              trig_in,
    input logic [15:0]       status_word,
    input logic [AW-1:0]     replay_ptr,
    input logic [NCH*DW-1:0] trend_out
);
    AST_RISE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl_word[0]) |=> (status_word[2:1] == 2'b00)); // R1

    AST_TRIG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (status_word[1] && !(ctrl_word[0] && !$past(ctrl_word[0]))) |=> status_word[1]); // R3

    AST_ABORT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $fell(ctrl_word[0]) && !status_word[2]) |=> status_word[2]); // R5

    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (status_word[2] && !(ctrl_word[0] && !$past(ctrl_word[0]))) |=> status_word[2]); // R6

    AST_ZERO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        !status_word[2] |-> (trend_out == '0)); // R7

    AST_AUTO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ctrl_word[15] && $past(ctrl_word[15])) |->
        (replay_ptr == $past(replay_ptr) || replay_ptr == $past(replay_ptr) + 1'b1)); // R10

    AST_NO_STRAY: assert property (@(posedge clk) disable iff (!rst_n)
        (status_word[15:3] == '0) && !status_word[0]); // R3
endmodule

bind trend_capture trend_capture_chk #(.NCH(NCH), .DW(DW), .AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl_word   (ctrl_word),
    .trig_in     (trig_in),
    .status_word (status_word),
    .replay_ptr  (replay_ptr),
    .trend_out   (trend_out)
);

// File: tb/trend_capture_tb.sv
module trend_capture_tb;
    localparam int NCH = 4, DW = 32, DEPTH = 64, PRE = 16, AW = 6, BW = 128;
    localparam int POST = DEPTH - PRE;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [15:0]   ctrl = '0;
    logic          trig = 1'b0, stb = 1'b0;
    logic [BW-1:0] sreal = '0, sint = '0;
    logic [15:0]   rate = '0;
    logic [AW-1:0] hptr = '0;
    logic [15:0]   status;
    logic [AW-1:0] rptr;
    logic [BW-1:0] tout;

    logic [BW-1:0] exp_mem [DEPTH];
    int  widx = 0;
    bit  coll = 0;
    int  n_cmp = 0, n_bad = 0;
    bit  done = 0;

    always #10 clk = ~clk;

    trend_capture #(.NCH(NCH), .DW(DW), .DEPTH(DEPTH), .PRE(PRE)) u_dut (
        .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl), .trig_in(trig),
        .smp_stb(stb), .src_real(sreal), .src_int(sint), .rate_div(rate),
        .host_ptr(hptr), .status_word(status), .replay_ptr(rptr),
        .trend_out(tout)
    );

    task automatic chk(input string req, input logic [BW-1:0] act, input logic [BW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [BW-1:0] pick(input logic [NCH-1:0] s);
        logic [BW-1:0] w;
        for (int i = 0; i < NCH; i++)
            w[i*DW +: DW] = s[i] ? sreal[i*DW +: DW] : sint[i*DW +: DW];
        return w;
    endfunction

    task automatic sample(input int n);
        for (int k = 0; k < n; k++) begin
            sreal = {$urandom, $urandom, $urandom, $urandom};
            sint  = {$urandom, $urandom, $urandom, $urandom};
            stb = 1'b1;
            if (coll) begin
                exp_mem[widx % DEPTH] = pick(ctrl[4:1]);
                widx++;
            end
            @(negedge clk);
        end
        stb = 1'b0;
    endtask

    task automatic pulse_trig();
        trig = 1'b1; @(negedge clk); trig = 1'b0;
    endtask

    task automatic arm(input logic [3:0] s);
        ctrl = {1'b0, 10'b0, s, 1'b1};
        widx = 0; coll = 1;
        @(negedge clk);
        chk("R1 status cleared on arm", BW'(status), BW'(0));
        chk("R7 zero while collecting", tout, '0);
    endtask

    task automatic stop_en();
        ctrl[0] = 1'b0; coll = 0;
        @(negedge clk);
    endtask

    task automatic read_all(input string tag);
        ctrl[15] = 1'b0;
        for (int k = 0; k < DEPTH; k++) begin
            hptr = AW'(k);
            @(negedge clk);
            chk("R9 pointer follows host", BW'(rptr), BW'(k));
            chk(tag, tout, exp_mem[(widx + k) % DEPTH]);
        end
    endtask

    task automatic t_reset();
        chk("R7 outputs zero after reset", tout, '0);
        chk("R3 status zero after reset", BW'(status), BW'(0));
    endtask

    task automatic t_full();
        arm(4'b0101);
        sample(20);
        chk("R7 zero during pre-trigger", tout, '0);
        pulse_trig();
        chk("R3 triggered set", BW'(status), BW'(16'h0002));
        sample(POST - 1);
        chk("R4 not complete before last strobe", BW'(status), BW'(16'h0002));
        sample(1);
        chk("R4 complete after last strobe", BW'(status), BW'(16'h0006));
        coll = 0;
        read_all("R8 R2 full capture readback");
    endtask

    task automatic t_frozen();
        pulse_trig();
        sample(10);
        chk("R6 status held with enable high", BW'(status), BW'(16'h0006));
        read_all("R6 R1 record unchanged, enable held");
        stop_en();
        chk("R6 status after enable fall", BW'(status), BW'(16'h0006));
        read_all("R6 record unchanged after enable fall");
    endtask

    task automatic t_abort_pre();
        arm(4'b1111);
        sample(5);
        stop_en();
        chk("R5 abort before trigger", BW'(status), BW'(16'h0004));
        read_all("R8 R5 readback after early stop");
    endtask

    task automatic t_abort_post();
        arm(4'b1010);
        sample(10);
        pulse_trig();
        sample(3);
        chk("R4 still collecting", BW'(status), BW'(16'h0002));
        stop_en();
        chk("R5 abort after trigger", BW'(status), BW'(16'h0006));
        read_all("R8 R2 readback after post abort");
    endtask

    task automatic t_auto();
        ctrl[15] = 1'b0; hptr = '0; rate = 16'd3;
        @(negedge clk);
        ctrl[15] = 1'b1;
        for (int j = 1; j <= 48; j++) begin
            @(negedge clk);
            chk("R10 auto step every rate+1", BW'(rptr), BW'(j / 4));
            chk("R8 auto replay data", tout, exp_mem[(widx + j / 4) % DEPTH]);
        end
        ctrl[15] = 1'b0; hptr = AW'(60); rate = 16'd0;
        @(negedge clk);
        chk("R9 host pointer", BW'(rptr), BW'(60));
        ctrl[15] = 1'b1;
        for (int j = 1; j <= 10; j++) @(negedge clk);
        chk("R10 pointer wraps", BW'(rptr), BW'(6));
        ctrl[15] = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_full();
        t_frozen();
        t_abort_pre();
        t_abort_post();
        t_auto();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule